// File: doc/BRIEF.md
# Divider and programmable timer unit

This block keeps a free-running 16-bit divider and an 8-bit programmable counter. The divider advances on every clock. The counter advances on a falling edge of one divider bit, ANDed with an enable. The control register picks that bit. When the counter wraps past 0xFF, it holds 0x00 for one cycle. On the next cycle it loads the reload register and pulses the interrupt request.

Software reaches the block through a small register bus. Writes take effect on a clock edge. Reads are combinational from the address. Any write to the divider address clears all 16 divider bits. Because the counter sees edges rather than levels, clearing the divider, or turning the enable off, while the chosen bit is high produces one extra count.

One divider bit is brought out for a sound sequencer elsewhere in the chip. It follows the divider, including its clears.

Top module: `tmr_unit`

## Requirements
- R1: A write of any data to bus address 0 clears the whole 16-bit divider at that clock edge. Address 0 reads 0x00 right after, and counting resumes from zero.
- R2: The divider advances by one on every clock. Address 0 reads its upper 8 bits, so it reads 0x01 exactly 256 cycles after a clear.
- R3: Control bits 1:0 pick the counting period: 00 gives 1024 clocks, 01 gives 16, 10 gives 64 and 11 gives 256 (divider bits 9, 3, 5, 7). Control bit 2 enables counting. After a divider clear, the first count appears period+1 edges later, and further counts follow every period.
- R4: Clearing the divider while the selected bit is 1 (timer enabled) adds one to the counter on the following edge. Clearing it while that bit is 0 leaves the counter unchanged.
- R5: Writing control bit 2 to 0 while the selected bit is 1 adds one to the counter on the following edge.
- R6: When a count occurs at 0xFF, the counter reads 0x00 for one cycle with no interrupt. On the next edge it loads the reload register (address 2), and `irq_o` is high for exactly that one cycle.
- R7: A write to the counter (address 1) during the 0x00 cycle cancels both the reload and the interrupt, and the written value is kept.
- R8: The control register (address 3) reads bits 7:3 as 1 and bits 2:0 as last written. The reload register reads back as written.
- R9: `seq_tap_o` equals divider bit 12, so it goes high 4096 cycles after a clear and returns low on a clear.
- R10: After reset, the divider, counter and reload register read 0x00, the control register reads 0xF8, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address: 0 divider, 1 counter, 2 reload, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | Timer interrupt request, one-cycle pulse |
| seq_tap_o | output | 1 | Divider bit for the sound sequencer |

## Verification
Each of the four period codes is run from a freshly cleared divider, with the counter sampled one cycle before and at the expected first count, and again a period later. This pins each code to its own divider bit and separates edge-triggered from level-triggered counting. Divider clears are issued with the selected bit both high and low, and the enable is dropped while that bit is high. Together these show whether the counter really watches a falling edge of the ANDed signal. The wrap case is sampled on three consecutive cycles, and then repeated with a counter write in the middle one. This shows the delayed reload and its cancellation.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_DIVHI  = 2'd0,
    REG_COUNT  = 2'd1,
    REG_RELOAD = 2'd2,
    REG_CTRL   = 2'd3
  } reg_sel_e;

  localparam int CTRL_W = 3;

  // divider bit whose falling edge advances the counter, per period code
  function automatic int tap_bit(input logic [1:0] code);
    case (code)
      2'd0:    return 9;
      2'd1:    return 3;
      2'd2:    return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  output logic [W-1:0] div_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_o <= '0;
    else if (clr_i) div_o <= '0;
    else            div_o <= div_o + 1'b1;
  end
endmodule

// File: rtl/tmr_tap_edge.sv
module tmr_tap_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_i,
  input  logic [1:0]   sel_i,
  input  logic         en_i,
  output logic         fall_o
);
  logic [3:0] taps;
  logic       level, level_q;

  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam int B = tmr_pkg::tap_bit(2'(g));
    assign taps[g] = div_i[B];
  end

  assign level = taps[sel_i] & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign fall_o = level_q & ~level;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         wr_cnt_i,
  input  logic         wr_rld_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         pend_o,
  output logic         irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      rld_o  <= '0;
      pend_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (wr_rld_i) rld_o <= wdata_i;
      if (wr_cnt_i) begin
        cnt_o  <= wdata_i;
        pend_o <= 1'b0;
      end else if (pend_o) begin
        cnt_o  <= rld_o;
        pend_o <= 1'b0;
        irq_o  <= 1'b1;
      end else if (inc_i) begin
        if (&cnt_o) begin
          cnt_o  <= '0;
          pend_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int DIV_W   = 16,
  parameter int CNT_W   = 8,
  parameter int SEQ_BIT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             seq_tap_o
);
  import tmr_pkg::*;

  localparam int CW = CTRL_W;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [CW-1:0]    ctrl_q;
  logic             pend_q, fall, wr_div, wr_cnt, wr_rld, wr_ctrl;

  assign wr_div  = bus_we && (bus_addr == REG_DIVHI);
  assign wr_cnt  = bus_we && (bus_addr == REG_COUNT);
  assign wr_rld  = bus_we && (bus_addr == REG_RELOAD);
  assign wr_ctrl = bus_we && (bus_addr == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CW-1:0];
  end

  tmr_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_i(wr_div), .div_o(div_q)
  );

  tmr_tap_edge #(.W(DIV_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .div_i(div_q), .sel_i(ctrl_q[1:0]),
    .en_i(ctrl_q[2]), .fall_o(fall)
  );

  tmr_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(fall), .wr_cnt_i(wr_cnt),
    .wr_rld_i(wr_rld), .wdata_i(bus_wdata), .cnt_o(cnt_q),
    .rld_o(rld_q), .pend_o(pend_q), .irq_o(irq_o)
  );

  always_comb begin
    case (bus_addr)
      REG_DIVHI:  bus_rdata = div_q[DIV_W-1 -: CNT_W];
      REG_COUNT:  bus_rdata = cnt_q;
      REG_RELOAD: bus_rdata = rld_q;
      default:    bus_rdata = {{(CNT_W-CW){1'b1}}, ctrl_q};
    endcase
  end

  assign seq_tap_o = div_q[SEQ_BIT];
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int DIV_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [DIV_W-1:0] div_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] rld_q,
  input logic             pend_q,
  input logic             irq_o
);
  assert_div_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0) |=> (div_q == '0));

  assert_div_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 2'd0) |=> (div_q == $past(div_q) + 1'b1));

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q == '0));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_irq_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_q == $past(rld_q)));

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && bus_we && bus_addr == 2'd1) |=> !irq_o);
endmodule

bind tmr_unit tmr_unit_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .div_q(div_q), .cnt_q(cnt_q), .rld_q(rld_q), .pend_q(pend_q), .irq_o(irq_o)
);

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_o, seq_tap_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  tmr_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .seq_tap_o(seq_tap_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); chk("R10 divider", v, 8'h00);
    rd(1, v); chk("R10 counter", v, 8'h00);
    rd(2, v); chk("R10 reload", v, 8'h00);
    rd(3, v); chk("R10 control", v, 8'hF8);
    chk("R10 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_divider;
    logic [7:0] v;
    wait_cyc(300);
    rd(0, v); chk("R2 running", v, 8'h01);
    wr(0, 8'h5A);
    rd(0, v); chk("R1 cleared", v, 8'h00);
    wait_cyc(255);
    rd(0, v); chk("R2 before 256", v, 8'h00);
    wait_cyc(1);
    rd(0, v); chk("R2 at 256", v, 8'h01);
  endtask

  task automatic t_rate(input logic [1:0] code, input int period);
    logic [7:0] v;
    wr(0, 8'h00);
    wr(3, {5'd0, 1'b1, code});
    wr(1, 8'h00);
    wait_cyc(period - 2);
    rd(1, v); chk($sformatf("R3 code %0d before", code), v, 8'h00);
    wait_cyc(1);
    rd(1, v); chk($sformatf("R3 code %0d first", code), v, 8'h01);
    wait_cyc(period);
    rd(1, v); chk($sformatf("R3 code %0d second", code), v, 8'h02);
  endtask

  task automatic t_clear_edge;
    logic [7:0] v;
    wr(3, 8'h05);
    wr(0, 8'h00); wr(1, 8'h10); wait_cyc(8);
    wr(0, 8'h00);
    rd(1, v); chk("R4 high: same cycle", v, 8'h10);
    wait_cyc(1);
    rd(1, v); chk("R4 high: extra count", v, 8'h11);
    wr(0, 8'h00); wr(1, 8'h10); wait_cyc(2);
    wr(0, 8'h00); wait_cyc(2);
    rd(1, v); chk("R4 low: no count", v, 8'h10);
  endtask

  task automatic t_disable_edge;
    logic [7:0] v;
    wr(3, 8'h05);
    wr(0, 8'h00); wr(1, 8'h20); wait_cyc(8);
    wr(3, 8'h01);
    wait_cyc(1);
    rd(1, v); chk("R5 disable count", v, 8'h21);
    wait_cyc(40);
    rd(1, v); chk("R5 stays disabled", v, 8'h21);
  endtask

  task automatic t_wrap(input bit cancel);
    logic [7:0] v;
    wr(3, 8'h05);
    wr(0, 8'h00); wr(2, 8'hA0); wr(1, 8'hFF);
    wait_cyc(14);
    rd(1, v); chk("R6 pre-wrap", v, 8'hFF);
    wait_cyc(1);
    rd(1, v); chk("R6 zero cycle", v, 8'h00);
    chk("R6 no irq yet", {7'd0, irq_o}, 8'h00);
    if (!cancel) begin
      wait_cyc(1);
      rd(1, v); chk("R6 reloaded", v, 8'hA0);
      chk("R6 irq high", {7'd0, irq_o}, 8'h01);
      wait_cyc(1);
      chk("R6 irq one cycle", {7'd0, irq_o}, 8'h00);
      rd(2, v); chk("R8 reload readback", v, 8'hA0);
    end else begin
      wr(1, 8'h33);
      rd(1, v); chk("R7 written kept", v, 8'h33);
      chk("R7 no irq", {7'd0, irq_o}, 8'h00);
      wait_cyc(1);
      rd(1, v); chk("R7 no reload", v, 8'h33);
      chk("R7 still no irq", {7'd0, irq_o}, 8'h00);
    end
  endtask

  task automatic t_ctrl_read;
    logic [7:0] v;
    wr(3, 8'h00); rd(3, v); chk("R8 ctrl 0", v, 8'hF8);
    wr(3, 8'h06); rd(3, v); chk("R8 ctrl 6", v, 8'hFE);
    wr(3, 8'hFF); rd(3, v); chk("R8 ctrl ff", v, 8'hFF);
    wr(3, 8'h00);
  endtask

  task automatic t_seq_tap;
    wr(0, 8'h00);
    wait_cyc(4095);
    chk("R9 low before 4096", {7'd0, seq_tap_o}, 8'h00);
    wait_cyc(1);
    chk("R9 high at 4096", {7'd0, seq_tap_o}, 8'h01);
    wr(0, 8'h00);
    chk("R9 cleared", {7'd0, seq_tap_o}, 8'h00);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_divider();
    t_rate(2'd1, 16);
    t_rate(2'd2, 64);
    t_rate(2'd3, 256);
    t_rate(2'd0, 1024);
    t_clear_edge();
    t_disable_edge();
    t_wrap(1'b0);
    t_wrap(1'b1);
    t_ctrl_read();
    t_seq_tap();
    finish_run();
  end
endmodule